// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

The block keeps a 16-bit count driven by one external pin. In event mode it counts one chosen pin edge, either rising or falling. In gated mode it counts a bus-clock/64 tick from the timer prescaler while the pin holds a chosen level. It also supplies the clock-enable tick for a separate main timer counter. That tick comes from the prescaler tick, from the accumulator's own input pulses, or from those pulses divided by 256 or by 65536. The divided ticks are taken from the rollover of the low byte and of the full word.

A single write port loads all control fields at once. Two sticky flags record activity: one for pin activity and one for count wraparound. Each flag is cleared by writing a one to its bit in the clear mask. Each flag drives its own interrupt request, gated by its own enable.

A four-state machine tracks the operating mode:
- ST_OFF: accumulator disabled.
- ST_EVENT: edge counting.
- ST_GATE_WAIT: gated mode, pin at the inactive level.
- ST_GATE_RUN: gated mode, pin at the active level.

Its transitions are:
- enable (ST_OFF to ST_EVENT or to ST_GATE_WAIT);
- disable (any state to ST_OFF);
- mode switch (between ST_EVENT and either gated state);
- gate open (ST_GATE_WAIT to ST_GATE_RUN);
- gate close (ST_GATE_RUN to ST_GATE_WAIT). This is the trailing edge, and it sets the input flag.

Top module: `pacc_top`

## Requirements
- R1: After reset the count is 0, both flags and both interrupt requests are 0, and the timer tick follows `tick_presc`.
- R2: With the accumulator enabled and `cfg_mode`=0, a pin edge of the kind selected by `cfg_edge` adds one to the count and sets the input flag. `cfg_edge`=1 selects rising edges and `cfg_edge`=0 selects falling edges. The opposite edge does nothing. The result is visible after the third rising clock edge following the pin change.
- R3: With `cfg_en`=0, pin activity changes neither the count nor the input flag.
- R4: With `cfg_mode`=1, each cycle with `tick_div64`=1 adds one to the count while the pin is at the active level. The active level is high for `cfg_edge`=0 and low for `cfg_edge`=1. No count is added while the pin is at the inactive level.
- R5: In gated mode the trailing pin edge sets the input flag: a falling edge for `cfg_edge`=0 and a rising edge for `cfg_edge`=1. The leading edge does not set the flag.
- R6: With `tmr_en`=0, no gated counting happens.
- R7: With the accumulator enabled, `cfg_clksel` selects the timer tick as follows:
  - 00: `tick_presc`;
  - 01: each count increment;
  - 10: each increment that carries out of the low 8 bits;
  - 11: each increment that wraps the full count.
- R8: With the accumulator disabled, the timer tick equals `tick_presc` whatever the value of `cfg_clksel`.
- R9: A new clock-select value drives the timer tick in the cycle right after the clock edge that accepts the write.
- R10: An increment from 0xFFFF gives 0x0000 and sets the overflow flag.
- R11: `ovf_irq` is 1 only when `cfg_ovf_ie`=1 and the overflow flag is set. `in_irq` is 1 only when `cfg_in_ie`=1 and the input flag is set.
- R12: A clear write with mask bit 0 clears the input flag, and mask bit 1 clears the overflow flag. A flag whose mask bit is 0 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads all control fields |
| cfg_en | input | 1 | Accumulator enable |
| cfg_mode | input | 1 | 0 = event mode, 1 = gated mode |
| cfg_edge | input | 1 | Edge or level select |
| cfg_clksel | input | 2 | Timer clock select |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cfg_in_ie | input | 1 | Input interrupt enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Bit 0 = input flag, bit 1 = overflow flag |
| pin_in | input | 1 | Raw asynchronous pin |
| tick_div64 | input | 1 | Bus clock/64 tick from the prescaler |
| tick_presc | input | 1 | Prescaler tick |
| tmr_en | input | 1 | Timer active |
| acc_val | output | 16 | Accumulator count |
| in_flag | output | 1 | Input flag |
| ovf_flag | output | 1 | Overflow flag |
| in_irq | output | 1 | Input interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| tmr_clk_tick | output | 1 | Clock enable for the timer counter |

## Verification
A pin change passes through two synchronizer stages and is then compared with a held copy. The count and the input flag therefore change at the third rising edge after the pin moves. The bench waits five cycles after each pin change before it samples.

A control write or a clear write takes effect at the edge that accepts it. The bench samples at the next falling edge.

The timer tick and the interrupt requests are combinational from the registered state. The bench counts them at each falling edge and compares the totals with the count's change over the same window. A gated tick held high for N edges must add exactly N to the count.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_WAIT = 2'd2,
        ST_GATE_RUN  = 2'd3
    } pa_state_e;

    typedef enum logic [1:0] {
        CS_PRESC    = 2'b00,
        CS_PACLK    = 2'b01,
        CS_DIV_LO   = 2'b10,
        CS_DIV_FULL = 2'b11
    } clk_sel_e;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/pacc_fsm.sv
module pacc_fsm
    import pacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      gated,
    input  logic      pol,
    input  logic      tmr_en,
    input  logic      tick64,
    input  logic      lvl,
    input  logic      rise,
    input  logic      fall,
    output logic      paclk,
    output logic      flag_set,
    output pa_state_e state_o
);
    pa_state_e state, nxt;
    logic      act;

    assign act     = pol ? ~lvl : lvl;
    assign state_o = state;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:       if (en) nxt = gated ? ST_GATE_WAIT : ST_EVENT;
            ST_EVENT:     if (!en) nxt = ST_OFF;
                          else if (gated) nxt = ST_GATE_WAIT;
            ST_GATE_WAIT: if (!en) nxt = ST_OFF;
                          else if (!gated) nxt = ST_EVENT;
                          else if (act) nxt = ST_GATE_RUN;
            ST_GATE_RUN:  if (!en) nxt = ST_OFF;
                          else if (!gated) nxt = ST_EVENT;
                          else if (!act) nxt = ST_GATE_WAIT;
            default:      nxt = ST_OFF;
        endcase
    end

    always_comb begin
        paclk    = 1'b0;
        flag_set = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_EVENT: begin
                paclk    = en & ~gated & (pol ? rise : fall);
                flag_set = paclk;
            end
            ST_GATE_WAIT: ;
            ST_GATE_RUN: begin
                paclk    = en & gated & act & tick64 & tmr_en;
                flag_set = en & gated & ~act;
            end
            default: ;
        endcase
    end

    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !(paclk || flag_set));
    a_r6_no_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && state != ST_EVENT) |-> !paclk);
    a_r5_lead_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATE_WAIT) |-> !flag_set);
endmodule

// File: rtl/pacc_clkmux.sv
module pacc_clkmux
    import pacc_pkg::*;
(
    input  logic     en,
    input  clk_sel_e sel,
    input  logic     presc,
    input  logic     paclk,
    input  logic     lo_roll,
    input  logic     full_roll,
    output logic     tick
);
    always_comb begin
        tick = presc;
        if (en) begin
            unique case (sel)
                CS_PRESC:    tick = presc;
                CS_PACLK:    tick = paclk;
                CS_DIV_LO:   tick = lo_roll;
                CS_DIV_FULL: tick = full_roll;
                default:     tick = presc;
            endcase
        end
    end
endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int LO_W      = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic             cfg_mode,
    input  logic             cfg_edge,
    input  logic [1:0]       cfg_clksel,
    input  logic             cfg_ovf_ie,
    input  logic             cfg_in_ie,
    input  logic             clr_we,
    input  logic [1:0]       clr_mask,
    input  logic             pin_in,
    input  logic             tick_div64,
    input  logic             tick_presc,
    input  logic             tmr_en,
    output logic [ACC_W-1:0] acc_val,
    output logic             in_flag,
    output logic             ovf_flag,
    output logic             in_irq,
    output logic             ovf_irq,
    output logic             tmr_clk_tick
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [LO_W-1:0]  LO_MAX  = {LO_W{1'b1}};

    logic       en_q, mode_q, edge_q, ovf_ie_q, in_ie_q;
    clk_sel_e   sel_q;
    logic [ACC_W-1:0] acc_q;
    logic       in_flag_q, ovf_flag_q;
    logic       lvl, rise, fall, paclk, flag_set, wrap;
    pa_state_e  state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mode_q   <= 1'b0;
            edge_q   <= 1'b0;
            sel_q    <= CS_PRESC;
            ovf_ie_q <= 1'b0;
            in_ie_q  <= 1'b0;
        end else if (cfg_we) begin
            en_q     <= cfg_en;
            mode_q   <= cfg_mode;
            edge_q   <= cfg_edge;
            sel_q    <= clk_sel_e'(cfg_clksel);
            ovf_ie_q <= cfg_ovf_ie;
            in_ie_q  <= cfg_in_ie;
        end
    end

    pacc_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    pacc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .gated(mode_q), .pol(edge_q),
        .tmr_en(tmr_en), .tick64(tick_div64), .lvl(lvl), .rise(rise),
        .fall(fall), .paclk(paclk), .flag_set(flag_set), .state_o(state)
    );

    assign wrap = paclk && (acc_q == ACC_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            in_flag_q  <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            if (paclk) acc_q <= acc_q + 1'b1;
            if (flag_set)                     in_flag_q <= 1'b1;
            else if (clr_we && clr_mask[0])   in_flag_q <= 1'b0;
            if (wrap)                         ovf_flag_q <= 1'b1;
            else if (clr_we && clr_mask[1])   ovf_flag_q <= 1'b0;
        end
    end

    pacc_clkmux u_mux (
        .en(en_q), .sel(sel_q), .presc(tick_presc), .paclk(paclk),
        .lo_roll(paclk && (acc_q[LO_W-1:0] == LO_MAX)),
        .full_roll(wrap), .tick(tmr_clk_tick)
    );

    assign acc_val  = acc_q;
    assign in_flag  = in_flag_q;
    assign ovf_flag = ovf_flag_q;
    assign in_irq   = in_ie_q & in_flag_q;
    assign ovf_irq  = ovf_ie_q & ovf_flag_q;

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> (acc_q == $past(acc_q) + 1'b1));
    a_r3_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> $stable(acc_q));
    a_r10_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (paclk && acc_q == ACC_MAX) |=> (ovf_flag_q && acc_q == '0));
    a_r8_presc_route: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (tmr_clk_tick == tick_presc));
    a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag_q |-> !ovf_irq) and (!in_flag_q |-> !in_irq));
    a_r12_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[1] && !wrap) |=> !ovf_flag_q);
endmodule

// File: tb/sim_pacc_top.sv
module sim_pacc_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_en = 0, cfg_mode = 0, cfg_edge = 0;
    logic [1:0] cfg_clksel = 2'b00;
    logic cfg_ovf_ie = 0, cfg_in_ie = 0, clr_we = 0;
    logic [1:0] clr_mask = 2'b00;
    logic pin_in = 0, tick_div64 = 0, tick_presc = 0, tmr_en = 1;
    logic [15:0] acc_val;
    logic in_flag, ovf_flag, in_irq, ovf_irq, tmr_clk_tick;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pacc_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
        .cfg_mode(cfg_mode), .cfg_edge(cfg_edge), .cfg_clksel(cfg_clksel),
        .cfg_ovf_ie(cfg_ovf_ie), .cfg_in_ie(cfg_in_ie), .clr_we(clr_we),
        .clr_mask(clr_mask), .pin_in(pin_in), .tick_div64(tick_div64),
        .tick_presc(tick_presc), .tmr_en(tmr_en), .acc_val(acc_val),
        .in_flag(in_flag), .ovf_flag(ovf_flag), .in_irq(in_irq),
        .ovf_irq(ovf_irq), .tmr_clk_tick(tmr_clk_tick)
    );

    // {en, mode, edge, pin_start, pin_end, exp_delta, exp_flag}
    localparam logic [6:0] VEC [9] = '{
        7'b1_0_1_0_1_1_1, 7'b1_0_1_1_0_0_0, 7'b1_0_0_1_0_1_1,
        7'b1_0_0_0_1_0_0, 7'b0_0_1_0_1_0_0, 7'b1_1_0_1_0_0_1,
        7'b1_1_0_0_1_0_0, 7'b1_1_1_0_1_0_1, 7'b1_1_1_1_0_0_0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cfg(input logic en, input logic md, input logic ed,
                       input logic [1:0] cs, input logic oie, input logic iie);
        step(1);
        cfg_en = en; cfg_mode = md; cfg_edge = ed; cfg_clksel = cs;
        cfg_ovf_ie = oie; cfg_in_ie = iie; cfg_we = 1;
        step(1);
        cfg_we = 0;
    endtask

    task automatic clr(input logic [1:0] m);
        step(1);
        clr_we = 1; clr_mask = m;
        step(1);
        clr_we = 0; clr_mask = 2'b00;
    endtask

    task automatic count_ticks(input int n, output int ticks, output logic [15:0] a0, output logic [15:0] a1);
        ticks = 0;
        @(negedge clk);
        a0 = acc_val;
        for (int i = 0; i < n; i++) begin
            if (tmr_clk_tick) ticks++;
            @(negedge clk);
        end
        a1 = acc_val;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] a0, a1, snap;
        int ticks, n;
        string tag;
        tick_presc = 1;
        step(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 acc", acc_val, 0);
        chk("R1 flags", {in_flag, ovf_flag}, 0);
        chk("R1 irqs", {in_irq, ovf_irq}, 0);
        chk("R1 tick follows presc", tmr_clk_tick, 1);
        tick_presc = 0;

        // Vector table: event, disabled and gated edge cases
        for (int v = 0; v < 9; v++) begin
            cfg(VEC[v][6], VEC[v][5], VEC[v][4], 2'b00, 0, 0);
            pin_in = VEC[v][3];
            step(5);
            clr(2'b11);
            @(negedge clk);
            snap = acc_val;
            step(1);
            pin_in = VEC[v][2];
            step(5);
            @(negedge clk);
            tag = !VEC[v][6] ? "R3" : (VEC[v][5] ? "R5" : "R2");
            chk({tag, " count delta"}, acc_val - snap, {31'b0, VEC[v][1]});
            chk({tag, " in_flag"}, in_flag, VEC[v][0]);
        end

        // R4 gated counting, active high, 10 ticks
        cfg(1, 1, 0, 2'b00, 0, 0);
        pin_in = 1;
        step(5);
        @(negedge clk); snap = acc_val;
        step(1); tick_div64 = 1;
        step(10); tick_div64 = 0;
        @(negedge clk);
        chk("R4 gated active count", acc_val - snap, 10);
        // R4 inactive level: no count
        pin_in = 0; step(5);
        @(negedge clk); snap = acc_val;
        step(1); tick_div64 = 1; step(10); tick_div64 = 0;
        @(negedge clk);
        chk("R4 gated inactive no count", acc_val - snap, 0);
        // R4 active low with edge=1
        cfg(1, 1, 1, 2'b00, 0, 0);
        step(5);
        @(negedge clk); snap = acc_val;
        step(1); tick_div64 = 1; step(7); tick_div64 = 0;
        @(negedge clk);
        chk("R4 gated active-low count", acc_val - snap, 7);
        // R6 timer off: no gated count
        tmr_en = 0;
        @(negedge clk); snap = acc_val;
        step(1); tick_div64 = 1; step(12); tick_div64 = 0;
        @(negedge clk);
        chk("R6 timer disabled no count", acc_val - snap, 0);
        tmr_en = 1;

        // R9 clock select switch takes effect right after the write edge
        cfg(1, 1, 0, 2'b00, 0, 0);
        pin_in = 1; tick_div64 = 1; step(6);
        @(negedge clk);
        chk("R9 tick before write", tmr_clk_tick, 0);
        step(1);
        cfg_clksel = 2'b01; cfg_we = 1;
        @(negedge clk);
        chk("R9 tick still old before edge", tmr_clk_tick, 0);
        step(1); cfg_we = 0;
        @(negedge clk);
        chk("R9 tick new select after edge", tmr_clk_tick, 1);

        // R7 select 01: one tick per increment
        count_ticks(300, ticks, a0, a1);
        chk("R7 sel01 ticks", ticks, 32'(a1 - a0));
        chk("R7 sel01 counted", (a1 - a0) > 0, 1);
        // R7 select 10: one tick per low-byte carry
        cfg(1, 1, 0, 2'b10, 0, 0);
        count_ticks(700, ticks, a0, a1);
        chk("R7 sel10 ticks", ticks, 32'((a1 >> 8) - (a0 >> 8)));
        chk("R7 sel10 nonzero", ticks > 1, 1);
        // R7 select 00 with enable: prescaler
        cfg(1, 1, 0, 2'b00, 0, 0);
        tick_presc = 1;
        count_ticks(20, ticks, a0, a1);
        chk("R7 sel00 presc ticks", ticks, 20);
        // R8 disabled: prescaler regardless of select 01
        cfg(0, 1, 0, 2'b01, 0, 0);
        count_ticks(20, ticks, a0, a1);
        chk("R8 disabled presc high", ticks, 20);
        tick_presc = 0;
        count_ticks(20, ticks, a0, a1);
        chk("R8 disabled presc low", ticks, 0);

        // R10 overflow with select 11
        cfg(1, 1, 0, 2'b11, 1, 0);
        step(4);
        clr(2'b10);
        ticks = 0; n = 0;
        @(negedge clk);
        while (!ovf_flag && n < 70000) begin
            if (tmr_clk_tick) ticks++;
            n++;
            @(negedge clk);
        end
        tick_div64 = 0;
        chk("R10 overflow flag set", ovf_flag, 1);
        chk("R10 wrapped to small", acc_val < 16'd4, 1);
        chk("R7 sel11 one tick per wrap", ticks, 1);
        chk("R11 ovf_irq with enable", ovf_irq, 1);
        chk("R11 in_irq without enable", in_irq, 0);
        // R11 disabled ovf enable
        cfg(1, 1, 0, 2'b11, 0, 1);
        @(negedge clk);
        chk("R11 ovf_irq masked", ovf_irq, 0);
        // R12 selective clear: set input flag via gate close, clear only ovf
        pin_in = 0; step(5);
        @(negedge clk);
        chk("R5 trailing flag", in_flag, 1);
        chk("R11 in_irq enabled", in_irq, 1);
        clr(2'b10);
        @(negedge clk);
        chk("R12 ovf cleared", ovf_flag, 0);
        chk("R12 in kept", in_flag, 1);
        clr(2'b01);
        @(negedge clk);
        chk("R12 in cleared", in_flag, 0);
        chk("R11 in_irq dropped", in_irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule